// File: doc/BRIEF.md
# Modular Exponentiation Accelerator Control and Interrupt Registers

This block is the register file that software uses to steer a modular-exponentiation accelerator. It sits on a simple word-wide register bus with an address, write data, a write strobe, a read strobe and read data. It holds the command word that drives the multiplier core: which pipeline section is active, which operands feed a single multiplication and where its result goes, the operating mode and a start request. The same word carries four status flags. The core sets each flag, and only software clears it.

The flag events come from the core as one-cycle pulses. Their OR forms one core interrupt request. A global enable and a per-source enable gate this request onto the interrupt line. A keyed write to a dedicated offset clears every register in the block and sends a one-cycle reset pulse to the rest of the core. A monitoring output stays high from the moment a start is issued until the core reports completion.

Field positions below use the usual LSB-0 numbering of the 32-bit data word. Register offsets are byte addresses.

Top module: `mexp_ctrl_regs`

## Requirements
- R1: Register offsets are as follows: command word at 0x000 (read/write), reset key at 0x100 (write-only), global enable at 0x21C, interrupt status at 0x220 (read-only), and source enable at 0x228. Read data appears on `bus_rdata` in the cycle after the read strobe is sampled. Unimplemented bits, unmapped offsets and the reset-key offset all read as zero, and writes to unimplemented bits have no effect.
- R2: The command word fields are as follows: pipeline select at bits 31:30 (01 lower, 10 upper, 11 full, 00 invalid), destination operand at 29:28, x operand at 27:26, y operand at 25:24, start at 23, and mode at 22 (0 single multiply, 1 exponentiation). Written fields read back unchanged and drive the matching outputs.
- R3: A write that sets start while the stored start bit is 0 produces a `start_pulse` exactly one cycle long, in the cycle after the write. Rewriting start as 1 while it is already stored as 1 produces no pulse.
- R4: When the written pipeline select is 00, the start request is refused. No pulse is produced, the start bit reads back 0, and the memory-collision flag keeps its previous value.
- R5: The sticky flags are ready (bit 15, set by `ev_done`), memory collision (bit 14), FIFO full (bit 13) and FIFO push error (bit 12). A pulse on an event sets its flag. A command write with a 0 in a flag's position clears that flag, and a 1 leaves it unchanged. When an event and a clear of the same flag occur in the same cycle, the flag ends up set.
- R6: Writing 0x0000000A to offset 0x100 clears the command word, the flags, both enables and `calc_busy`, and raises `core_rst` for one cycle. Any other value written there has no effect.
- R7: Interrupt status bit 0 is the OR of the four flags. The global enable is held in bit 31 of its register, and the source enable in bit 0 of its register.
- R8: `irq` is high exactly when the global enable, the source enable and the interrupt status are all 1.
- R9: While mode is 1, the `dst_sel`, `x_sel` and `y_sel` outputs are 0. The stored selector values still read back unchanged.
- R10: `calc_busy` rises in the same cycle as a `start_pulse`. It falls in the cycle after an `ev_done` pulse that does not coincide with a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| ev_done | input | 1 | Core pulse: operation finished |
| ev_mem_collide | input | 1 | Core pulse: memory write collision |
| ev_fifo_full | input | 1 | Core pulse: FIFO became full |
| ev_fifo_push_err | input | 1 | Core pulse: FIFO push error |
| pipe_sel | output | 2 | Active pipeline section |
| dst_sel | output | 2 | Result operand select, 0 in exponentiation mode |
| x_sel | output | 2 | x operand select, 0 in exponentiation mode |
| y_sel | output | 2 | y operand select, 0 in exponentiation mode |
| exp_mode | output | 1 | 1 selects exponentiation |
| start_pulse | output | 1 | One-cycle start strobe to the core |
| core_rst | output | 1 | One-cycle reset to the rest of the core |
| calc_busy | output | 1 | High while an operation is in progress |
| irq | output | 1 | Gated core interrupt |

## Verification
The assertions check four rules on every cycle. A start strobe never lasts two cycles and never appears with an invalid pipeline select. The busy output never rises without a start strobe. A flag event is never lost to a simultaneous clear. A keyed reset leaves the command word, the flags and the interrupt line clear. The interrupt line is also checked against the flag bank, which a separate module drives. Some behaviours only the bench scenarios can show. These include the exact readback layout of every register, the refusal of a start while the memory flag keeps its value, the masking of the operand selectors in exponentiation mode, and a reset-key write with the wrong value having no effect. The random mix of writes, event pulses and reads exercises how the flags, the enables and the busy state interact over long sequences.

// File: rtl/mexp_regs_pkg.sv
package mexp_regs_pkg;

  localparam int REG_W     = 32;
  localparam int NUM_FLAGS = 4;
  localparam int FLAG_TOP  = 15;

  localparam logic [11:0] OFF_CMD  = 12'h000;
  localparam logic [11:0] OFF_KEY  = 12'h100;
  localparam logic [11:0] OFF_GEN  = 12'h21C;
  localparam logic [11:0] OFF_STAT = 12'h220;
  localparam logic [11:0] OFF_SEN  = 12'h228;

  localparam logic [REG_W-1:0] RESET_KEY = 32'h0000_000A;

  typedef enum logic [1:0] {
    PSEL_NONE = 2'b00,
    PSEL_LOW  = 2'b01,
    PSEL_HIGH = 2'b10,
    PSEL_FULL = 2'b11
  } psel_e;

  typedef struct packed {
    psel_e      psel;
    logic [1:0] dst;
    logic [1:0] xop;
    logic [1:0] yop;
    logic       start;
    logic       expm;
  } cmd_t;

  localparam int CMD_W = $bits(cmd_t);

  // bus numbering counts from the MSB; convert to an LSB-0 index
  function automatic int unsigned lsb_pos(input int unsigned bus_bit);
    return REG_W - 1 - bus_bit;
  endfunction

  function automatic int unsigned flag_pos(input int unsigned idx);
    return FLAG_TOP - idx;
  endfunction

  function automatic cmd_t unpack_cmd(input logic [REG_W-1:0] w);
    return cmd_t'(w[REG_W-1 -: CMD_W]);
  endfunction

  function automatic logic [REG_W-1:0] pack_cmd(input cmd_t c,
                                                input logic [NUM_FLAGS-1:0] f);
    logic [REG_W-1:0] w;
    w = '0;
    w[REG_W-1 -: CMD_W] = c;
    for (int i = 0; i < NUM_FLAGS; i++) w[flag_pos(i)] = f[i];
    return w;
  endfunction

  function automatic logic [NUM_FLAGS-1:0] keep_mask(input logic [REG_W-1:0] w);
    logic [NUM_FLAGS-1:0] k;
    for (int i = 0; i < NUM_FLAGS; i++) k[i] = w[flag_pos(i)];
    return k;
  endfunction

endpackage

// File: rtl/mexp_cmd_word.sv
module mexp_cmd_word
  import mexp_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_all,
  input  logic             wr_cmd,
  input  logic [REG_W-1:0] wdata,
  input  logic             ev_done,
  output cmd_t             cmd_q,
  output logic             start_pulse,
  output logic             busy
);

  cmd_t wr_c;
  cmd_t wr_store;
  logic psel_ok;
  logic start_go;

  always_comb begin
    wr_c           = unpack_cmd(wdata);
    psel_ok        = (wr_c.psel != PSEL_NONE);
    wr_store       = wr_c;
    wr_store.start = wr_c.start && psel_ok;
    start_go       = wr_cmd && wr_c.start && !cmd_q.start && psel_ok;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      cmd_q       <= '0;
      start_pulse <= 1'b0;
      busy        <= 1'b0;
    end else begin
      start_pulse <= start_go;
      if (wr_cmd) cmd_q <= wr_store;
      if (start_go)     busy <= 1'b1;
      else if (ev_done) busy <= 1'b0;
    end
  end

  p_start_single_r3: assert property (@(posedge clk) disable iff (rst)
    start_pulse |=> !start_pulse);

  p_start_needs_psel_r4: assert property (@(posedge clk) disable iff (rst)
    start_pulse |-> (cmd_q.psel != PSEL_NONE));

  p_busy_from_start_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> start_pulse);

endmodule

// File: rtl/mexp_flag_bank.sv
module mexp_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_all,
  input  logic         wr_cmd,
  input  logic [N-1:0] keep,
  input  logic [N-1:0] ev,
  output logic [N-1:0] flags,
  output logic         any_set
);

  for (genvar g = 0; g < N; g++) begin : g_flag
    logic bit_q;
    always_ff @(posedge clk) begin
      if (rst || clr_all) bit_q <= 1'b0;
      else                bit_q <= (wr_cmd ? (bit_q & keep[g]) : bit_q) | ev[g];
    end
    assign flags[g] = bit_q;

    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
      (ev[g] && !clr_all) |=> flags[g]);
  end

  assign any_set = |flags;

endmodule

// File: rtl/mexp_irq_ctrl.sv
module mexp_irq_ctrl
  import mexp_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_all,
  input  logic             wr_gen,
  input  logic             wr_sen,
  input  logic [REG_W-1:0] wdata,
  input  logic             cis,
  output logic             gen_q,
  output logic             sen_q,
  output logic             irq
);

  localparam int GEN_BIT = lsb_pos(0);
  localparam int SEN_BIT = lsb_pos(31);

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      gen_q <= 1'b0;
      sen_q <= 1'b0;
    end else begin
      if (wr_gen) gen_q <= wdata[GEN_BIT];
      if (wr_sen) sen_q <= wdata[SEN_BIT];
    end
  end

  assign irq = gen_q & sen_q & cis;

endmodule

// File: rtl/mexp_ctrl_regs.sv
module mexp_ctrl_regs
  import mexp_regs_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic              ev_done,
  input  logic              ev_mem_collide,
  input  logic              ev_fifo_full,
  input  logic              ev_fifo_push_err,
  output logic [1:0]        pipe_sel,
  output logic [1:0]        dst_sel,
  output logic [1:0]        x_sel,
  output logic [1:0]        y_sel,
  output logic              exp_mode,
  output logic              start_pulse,
  output logic              core_rst,
  output logic              calc_busy,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFF_CMD);
  localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(OFF_KEY);
  localparam logic [ADDR_W-1:0] A_GEN  = ADDR_W'(OFF_GEN);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_SEN  = ADDR_W'(OFF_SEN);
  localparam int STAT_BIT = lsb_pos(31);
  localparam int GEN_BIT  = lsb_pos(0);

  logic wr_cmd, wr_gen, wr_sen, clr_all;
  logic [NUM_FLAGS-1:0] ev_vec, keep, flags;
  logic any_flag, gen_q, sen_q;
  cmd_t cmd_q;
  logic [REG_W-1:0] rd_mux;

  assign wr_cmd  = bus_wr && (bus_addr == A_CMD);
  assign wr_gen  = bus_wr && (bus_addr == A_GEN);
  assign wr_sen  = bus_wr && (bus_addr == A_SEN);
  assign clr_all = bus_wr && (bus_addr == A_KEY) && (bus_wdata == RESET_KEY);
  assign ev_vec  = {ev_fifo_push_err, ev_fifo_full, ev_mem_collide, ev_done};
  assign keep    = keep_mask(bus_wdata);

  mexp_cmd_word i_cmd (
    .clk(clk), .rst(rst), .clr_all(clr_all), .wr_cmd(wr_cmd),
    .wdata(bus_wdata), .ev_done(ev_done), .cmd_q(cmd_q),
    .start_pulse(start_pulse), .busy(calc_busy)
  );

  mexp_flag_bank #(.N(NUM_FLAGS)) i_flags (
    .clk(clk), .rst(rst), .clr_all(clr_all), .wr_cmd(wr_cmd),
    .keep(keep), .ev(ev_vec), .flags(flags), .any_set(any_flag)
  );

  mexp_irq_ctrl i_irq (
    .clk(clk), .rst(rst), .clr_all(clr_all), .wr_gen(wr_gen), .wr_sen(wr_sen),
    .wdata(bus_wdata), .cis(any_flag), .gen_q(gen_q), .sen_q(sen_q), .irq(irq)
  );

  // operand selectors are meaningless during exponentiation
  assign pipe_sel = cmd_q.psel;
  assign exp_mode = cmd_q.expm;
  assign dst_sel  = cmd_q.expm ? 2'b00 : cmd_q.dst;
  assign x_sel    = cmd_q.expm ? 2'b00 : cmd_q.xop;
  assign y_sel    = cmd_q.expm ? 2'b00 : cmd_q.yop;

  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      A_CMD:   rd_mux = pack_cmd(cmd_q, flags);
      A_GEN:   rd_mux[GEN_BIT]  = gen_q;
      A_STAT:  rd_mux[STAT_BIT] = any_flag;
      A_SEN:   rd_mux[STAT_BIT] = sen_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      bus_rdata <= '0;
      core_rst  <= 1'b0;
    end else begin
      bus_rdata <= bus_rd ? rd_mux : '0;
      core_rst  <= 1'b0;
    end
    if (!rst && clr_all) core_rst <= 1'b1;
  end

  p_soft_reset_clears_r6: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (flags == '0) && !irq && (pipe_sel == 2'b00) && core_rst && !calc_busy);

  p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> any_flag);

endmodule

// File: tb/test_mexp_ctrl_regs.sv
module test_mexp_ctrl_regs;

  localparam logic [9:0] T_CMD = 10'h000, T_KEY = 10'h100, T_GEN = 10'h21C,
                         T_STAT = 10'h220, T_SEN = 10'h228;

  logic clk = 1'b0, rst = 1'b1;
  logic [9:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic ev_done = 0, ev_mem = 0, ev_full = 0, ev_perr = 0;
  logic [1:0] pipe_sel, dst_sel, x_sel, y_sel;
  logic exp_mode, start_pulse, core_rst, calc_busy, irq;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // bench model
  logic [1:0] mp = 0, md = 0, mx = 0, my = 0;
  logic ms = 0, mm = 0, mg = 0, mc = 0, mb = 0;
  logic [3:0] mf = 0;

  always #5 clk = ~clk;

  mexp_ctrl_regs i_mexp_ctrl_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .ev_done(ev_done), .ev_mem_collide(ev_mem), .ev_fifo_full(ev_full),
    .ev_fifo_push_err(ev_perr), .pipe_sel(pipe_sel), .dst_sel(dst_sel),
    .x_sel(x_sel), .y_sel(y_sel), .exp_mode(exp_mode),
    .start_pulse(start_pulse), .core_rst(core_rst), .calc_busy(calc_busy),
    .irq(irq)
  );

  function automatic logic [31:0] f_cmd_word();
    return (32'(mp) << 30) | (32'(md) << 28) | (32'(mx) << 26) | (32'(my) << 24) |
           (32'(ms) << 23) | (32'(mm) << 22) | (32'(mf[0]) << 15) |
           (32'(mf[1]) << 14) | (32'(mf[2]) << 13) | (32'(mf[3]) << 12);
  endfunction

  function automatic logic f_irq();
    return mg && mc && (mf != 0);
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit w, input logic [9:0] a, input logic [31:0] d,
                      input logic [3:0] ev);
    bit ep = 0, ec = 0;
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_wdata = d;
    {ev_perr, ev_full, ev_mem, ev_done} = ev;
    @(negedge clk);
    bus_wr = 0; {ev_perr, ev_full, ev_mem, ev_done} = 4'b0;
    if (w && a == T_KEY && d == 32'h0000_000A) begin
      mp = 0; md = 0; mx = 0; my = 0; ms = 0; mm = 0; mf = 0; mg = 0; mc = 0; mb = 0;
      ec = 1;
    end else begin
      if (w && a == T_CMD) begin
        ep = d[23] && !ms && (d[31:30] != 2'b00);
        mp = d[31:30]; md = d[29:28]; mx = d[27:26]; my = d[25:24];
        ms = d[23] && (d[31:30] != 2'b00); mm = d[22];
        mf = mf & {d[12], d[13], d[14], d[15]};
      end
      if (w && a == T_GEN) mg = d[31];
      if (w && a == T_SEN) mc = d[0];
      mf = mf | ev;
      if (ep) mb = 1; else if (ev[0]) mb = 0;
    end
    chk(32'(start_pulse), 32'(ep), "R3/R4 start_pulse");
    chk(32'(core_rst), 32'(ec), "R6 core_rst");
    chk(32'(pipe_sel), 32'(mp), "R2 pipe_sel");
    chk(32'(exp_mode), 32'(mm), "R2 exp_mode");
    chk({26'b0, dst_sel, x_sel, y_sel}, mm ? 32'b0 : {26'b0, md, mx, my}, "R9 operand outputs");
    chk(32'(irq), 32'(f_irq()), "R8 irq");
    chk(32'(calc_busy), 32'(mb), "R10 calc_busy");
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0; d = bus_rdata;
  endtask

  task automatic rd_chk(input logic [9:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    rd(a, v);
    chk(v, exp, tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;

    // reset state, R1
    rd_chk(T_CMD, 32'h0, "R1 reset cmd");
    rd_chk(T_GEN, 32'h0, "R1 reset gen");
    rd_chk(T_STAT, 32'h0, "R1 reset stat");
    rd_chk(T_SEN, 32'h0, "R1 reset sen");
    chk({start_pulse, core_rst, calc_busy, irq}, 4'b0, "R1 reset outputs");

    // all ones: unimplemented bits masked, flags not set by writing 1 (R1 R2 R5 R3)
    step(1, T_CMD, 32'hFFFF_FFFF, 4'b0);
    @(negedge clk);
    chk(32'(start_pulse), 0, "R3 pulse one cycle only");
    rd_chk(T_CMD, f_cmd_word(), "R1 R2 cmd readback");
    chk(f_cmd_word(), 32'hFFC0_0000, "R2 bench field layout");
    rd_chk(10'h004, 32'h0, "R1 unmapped reads zero");
    step(1, T_CMD, 32'hFFBF_F000, 4'b0);   // start again while stored: no pulse, R3
    step(1, T_CMD, 32'h7F80_F000, 4'b0);   // exp mode 0, psel 01, start still 1
    chk({26'b0, dst_sel, x_sel, y_sel}, 32'h3F, "R2 operand outputs in multiply mode");

    // completion, R10 R5 R7
    step(0, T_CMD, 0, 4'b0001);
    rd_chk(T_CMD, f_cmd_word(), "R5 ready flag set");
    rd_chk(T_STAT, 32'h1, "R7 status follows flags");
    step(1, T_GEN, 32'h8000_0000, 4'b0);
    step(1, T_SEN, 32'h0000_0001, 4'b0);
    chk(32'(irq), 1, "R8 irq with both enables");
    rd_chk(T_GEN, 32'h8000_0000, "R7 gen readback");
    rd_chk(T_SEN, 32'h1, "R7 sen readback");
    step(1, T_GEN, 32'h0, 4'b0);
    chk(32'(irq), 0, "R8 global enable gates");
    step(1, T_GEN, 32'h8000_0000, 4'b0);

    // clear ready (write 0 at bit 15, keep start)
    step(1, T_CMD, 32'h7F80_7000, 4'b0);
    rd_chk(T_STAT, 32'h0, "R5 R7 software clear");

    // set wins over simultaneous clear, R5
    step(0, T_CMD, 0, 4'b0010);
    step(1, T_CMD, 32'h7F80_0000, 4'b0010);
    rd_chk(T_CMD, f_cmd_word(), "R5 set wins");
    chk(32'(mf[1]), 1, "R5 model mem flag");

    // refused start, R4
    step(1, T_CMD, 32'h0000_F000, 4'b0);
    step(1, T_CMD, 32'h3F80_F000, 4'b0);
    rd_chk(T_CMD, 32'h3F00_4000, "R4 refused start keeps mem flag");

    // exponentiation mode masks selectors, R9
    step(1, T_CMD, 32'h5E40_F000, 4'b0);
    chk({26'b0, dst_sel, x_sel, y_sel}, 0, "R9 selectors masked");
    rd_chk(T_CMD, f_cmd_word(), "R9 selectors retained");

    // wrong key, R6
    step(1, T_KEY, 32'h0000_0005, 4'b0);
    rd_chk(T_CMD, f_cmd_word(), "R6 wrong key no effect");
    rd_chk(T_KEY, 32'h0, "R6 key offset reads zero");
    step(1, T_CMD, 32'h5EC0_F000, 4'b0);
    step(1, T_KEY, 32'h0000_000A, 4'b0100);
    rd_chk(T_CMD, 32'h0, "R6 key clears cmd");
    rd_chk(T_GEN, 32'h0, "R6 key clears gen");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      logic [31:0] d;
      logic [3:0] e;
      op = $urandom_range(0, 5);
      d = $urandom;
      e = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'b0;
      case (op)
        0, 1: step(1, T_CMD, d, e);
        2: step(0, T_CMD, 0, e | 4'($urandom_range(0, 1)));
        3: rd_chk(T_CMD, f_cmd_word(), "R2 R5 random cmd readback");
        4: rd_chk(T_STAT, 32'(mf != 0), "R7 random status");
        default: step(1, ($urandom_range(0, 1) == 0) ? T_GEN : T_SEN, d, e);
      endcase
    end
    rd_chk(T_CMD, f_cmd_word(), "R5 final cmd");
    rd_chk(T_GEN, {mg, 31'b0}, "R7 final gen");
    rd_chk(T_SEN, 32'(mc), "R7 final sen");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule